// File: doc/BRIEF.md
# Nibble Lookup Table Multiplier

This block multiplies a 16-bit operand X, which may change on every clock, by a 16-bit operand A, which changes rarely, and gives the 32-bit unsigned product. It uses no multiplier array. X is cut into four 4-bit nibbles. Each nibble is the read address of its own 16-entry RAM table. Every table holds the sixteen multiples of A, from 0 times A up to 15 times A. The table outputs are 20-bit partial products. Two 24-bit adders join them in pairs, each with the upper partial product moved up by four bits. A 32-bit adder then joins the two byte sums, with the upper sum moved up by eight bits.

A sequencer outside this block fills the tables through one shared write port. That port has a 4-bit entry index, a 20-bit word and a write enable, and each write lands in all four tables at the same time. After the tables are loaded, a new X can enter on every clock. Each result leaves the block three cycles later with a valid flag: one cycle for the table read, one for the byte adders and one for the final adder.

Top module: `nibble_lut_mult`

## Requirements
- R1: While reset is held and right after it, `prod_valid` is 0 and `prod` is 0.
- R2: `prod_valid` equals `x_valid` delayed by exactly three rising clock edges.
- R3: When every table entry k holds k times A, the product of an accepted X is X times A. When every stored entry is at most 15 times (2^16 - 1), neither adder stage overflows.
- R4: Nibble i of X (bits 4i+3 down to 4i, i = 0 for the least significant) reads its own table, and that entry is weighted by 16 to the power i in the result.
- R5: A new X accepted on every consecutive cycle gives a correct result on every consecutive cycle, in input order.
- R6: One write with `tbl_we` = 1 stores `tbl_data` at index `tbl_addr` in all four tables, and a lookup in any nibble position sees it from the next cycle on.
- R7: A lookup in the same cycle as a write to the same index returns that entry's previous content.
- R8: While `prod_valid` is 0, `prod` keeps the last valid result.
- R9: With A = FFFF hex and X = FFFF hex, the product is FFFE0001 hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_valid | input | 1 | X operand present this cycle |
| x_in | input | 16 | Fast operand X |
| tbl_we | input | 1 | Write enable for all four tables |
| tbl_addr | input | 4 | Table index to write |
| tbl_data | input | 20 | Multiple of A stored at that index |
| prod_valid | output | 1 | Product valid |
| prod | output | 32 | Product of X and A |

## Verification
A table write and a lookup can happen in the same cycle. The hard case is a write to the same index that one or more nibbles of the accepted X read. The bench provokes this by rewriting one entry while it presents an X whose nibbles all select that entry. It then repeats the same X on the next cycle. The first result must be built from the old entry and the second from the new one, judged against a bench-side copy of the tables that is updated only after each lookup's expected value is formed.

// File: rtl/nlm_pkg.sv
package nlm_pkg;
    localparam int NIB_W     = 4;
    localparam int TBL_DEPTH = 1 << NIB_W;
    localparam int NUM_NIB   = 4;

    function automatic int pp_width(input int a_w);
        return a_w + NIB_W;
    endfunction
endpackage

// File: rtl/nlm_table.sv
module nlm_table #(
    parameter int DATA_W = 20,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    // storage has no reset; the sequencer fills it before use
    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d = mem[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R7: a read that meets a write returns the content from before the write
    assert_read_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(we) && ($past(wr_addr) == $past(rd_addr)))
            |-> (rd_data == $past(mem[rd_addr])));
endmodule

// File: rtl/nlm_shift_add.sv
module nlm_shift_add #(
    parameter int IN_W  = 20,
    parameter int SHIFT = 4,
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  lo,
    input  logic [IN_W-1:0]  hi,
    output logic             out_valid,
    output logic [OUT_W-1:0] sum
);
    localparam int SW = OUT_W + 1;

    typedef struct packed {
        logic             v;
        logic [OUT_W-1:0] s;
    } stage_t;

    stage_t          st_d, st_q;
    logic [SW-1:0]   lo_ext, hi_ext, wide;

    always_comb begin
        lo_ext = SW'(lo);
        hi_ext = SW'(hi) << SHIFT;
        wide   = lo_ext + hi_ext;
        st_d   = st_q;
        st_d.v = in_valid;
        if (in_valid) st_d.s = wide[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v;
    assign sum       = st_q.s;

    // R3: bounded partial products never carry out of the stage width
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (wide[OUT_W] == 1'b0));

    // R8: the stage output only moves on an accepted value
    assert_stage_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(sum));
endmodule

// File: rtl/nibble_lut_mult.sv
module nibble_lut_mult
    import nlm_pkg::*;
#(
    parameter int A_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   x_valid,
    input  logic [NUM_NIB*NIB_W-1:0] x_in,
    input  logic                   tbl_we,
    input  logic [NIB_W-1:0]       tbl_addr,
    input  logic [A_W+NIB_W-1:0]   tbl_data,
    output logic                   prod_valid,
    output logic [NUM_NIB*NIB_W+A_W-1:0] prod
);
    localparam int X_W    = NUM_NIB * NIB_W;
    localparam int PP_W   = pp_width(A_W);
    localparam int BYTE_W = PP_W + NIB_W;
    localparam int P_W    = X_W + A_W;
    localparam int PAIRS  = NUM_NIB / 2;

    typedef struct packed {
        logic v;
    } rd_stage_t;

    rd_stage_t rs_d, rs_q;

    logic [PP_W-1:0]   pp     [NUM_NIB];
    logic [BYTE_W-1:0] bsum   [PAIRS];
    logic [PAIRS-1:0]  bvalid;

    always_comb begin
        rs_d   = rs_q;
        rs_d.v = x_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    // one table per nibble, all sharing the write port
    for (genvar i = 0; i < NUM_NIB; i++) begin : g_tbl
        nlm_table #(
            .DATA_W (PP_W),
            .ADDR_W (NIB_W)
        ) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (tbl_we),
            .wr_addr (tbl_addr),
            .wr_data (tbl_data),
            .rd_en   (x_valid),
            .rd_addr (x_in[i*NIB_W +: NIB_W]),
            .rd_data (pp[i])
        );
    end

    // byte level: upper nibble product weighted by 16
    for (genvar j = 0; j < PAIRS; j++) begin : g_byte
        nlm_shift_add #(
            .IN_W  (PP_W),
            .SHIFT (NIB_W),
            .OUT_W (BYTE_W)
        ) u_badd (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (rs_q.v),
            .lo        (pp[2*j]),
            .hi        (pp[2*j+1]),
            .out_valid (bvalid[j]),
            .sum       (bsum[j])
        );
    end

    // final level: upper byte sum weighted by 256
    nlm_shift_add #(
        .IN_W  (BYTE_W),
        .SHIFT (2*NIB_W),
        .OUT_W (P_W)
    ) u_fadd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (bvalid[0]),
        .lo        (bsum[0]),
        .hi        (bsum[1]),
        .out_valid (prod_valid),
        .sum       (prod)
    );

    // R2: fixed three-edge latency from accepted X to result
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid == $past(x_valid, 3));

    // R8: the product holds while no result is presented
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_valid |-> $stable(prod));

    // R2: both byte adders always advance together
    assert_pair_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid[0] == bvalid[PAIRS-1]);

    // R1: nothing valid straight out of reset
    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !prod_valid);
endmodule

// File: tb/nibble_lut_mult_bench.sv
module nibble_lut_mult_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        x_valid = 1'b0;
    logic [15:0] x_in = '0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [19:0] tbl_data = '0;
    logic        prod_valid;
    logic [31:0] prod;

    int checks = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R3";

    logic [19:0] model [16];
    logic        pv [1:3];
    logic [31:0] pe [1:3];
    logic [31:0] hold_exp = '0;

    always #10 clk = ~clk;

    nibble_lut_mult u_nibble_lut_mult (
        .clk(clk), .rst_n(rst_n), .x_valid(x_valid), .x_in(x_in),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .prod_valid(prod_valid), .prod(prod)
    );

    function automatic logic [31:0] expect_prod(input logic [15:0] x);
        logic [63:0] acc = 0;
        for (int i = 0; i < 4; i++)
            acc += 64'(model[x[4*i +: 4]]) << (4*i);
        return acc[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, then check the result due three edges later
    task automatic cyc(input logic v, input logic [15:0] x,
                       input logic we, input logic [3:0] a, input logic [19:0] d);
        x_valid  = v;  x_in = x;
        tbl_we   = we; tbl_addr = a; tbl_data = d;
        pv[3] = pv[2]; pe[3] = pe[2];
        pv[2] = pv[1]; pe[2] = pe[1];
        pv[1] = v;     pe[1] = expect_prod(x); // R7: formed before the write lands
        if (we) model[a] = d;
        @(negedge clk);
        if (pv[3]) hold_exp = pe[3];
        check("R2", 32'(prod_valid), 32'(pv[3]));
        check(pv[3] ? cur_req : "R8", prod, hold_exp);
    endtask

    task automatic load_a(input logic [15:0] a);
        for (int k = 0; k < 16; k++) cyc(1'b0, '0, 1'b1, 4'(k), 20'(k) * 20'(a));
        cyc(1'b0, '0, 1'b0, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 1; i <= 3; i++) begin pv[i] = 1'b0; pe[i] = '0; end
        for (int k = 0; k < 16; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", 32'(prod_valid), 32'd0);
        check("R1", prod, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(prod_valid), 32'd0);
        check("R1", prod, 32'd0);

        // R3 / R6: load and multiply with a plain A
        load_a(16'h1234);
        cur_req = "R3";
        cyc(1'b1, 16'h0001, 0, 0, 0);
        cyc(1'b1, 16'hABCD, 0, 0, 0);
        cyc(1'b1, 16'h0000, 0, 0, 0);
        // R4: one non-zero nibble in each position
        cur_req = "R4";
        for (int i = 0; i < 4; i++) cyc(1'b1, 16'(16'h9 << (4*i)), 0, 0, 0);
        // R5: back-to-back stream
        cur_req = "R5";
        for (int n = 0; n < 40; n++) cyc(1'b1, 16'($urandom), 0, 0, 0);
        // R8: gaps in the stream, then idle
        cur_req = "R8";
        for (int n = 0; n < 40; n++) cyc(1'($urandom % 4 != 0), 16'($urandom), 0, 0, 0);
        for (int n = 0; n < 5; n++) cyc(1'b0, 16'($urandom), 0, 0, 0);
        // R7 then R6: rewrite entry 5 while all nibbles read it, then read again
        cur_req = "R7";
        cyc(1'b1, 16'h5555, 1'b1, 4'd5, 20'd5 * 20'hBEEF);
        cur_req = "R6";
        cyc(1'b1, 16'h5555, 0, 0, 0);
        cyc(1'b1, 16'h0500, 0, 0, 0);
        // R9: largest operands
        load_a(16'hFFFF);
        cur_req = "R9";
        cyc(1'b1, 16'hFFFF, 0, 0, 0);
        for (int n = 0; n < 3; n++) cyc(1'b0, '0, 0, 0, 0);
        check("R9", prod, 32'hFFFE0001);
        // R3: several random A values with random streams
        cur_req = "R3";
        for (int r = 0; r < 6; r++) begin
            load_a(16'($urandom));
            for (int n = 0; n < 30; n++) cyc(1'($urandom % 3 != 0), 16'($urandom), 0, 0, 0);
        end
        for (int n = 0; n < 4; n++) cyc(1'b0, '0, 0, 0, 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule